// File: doc/BRIEF.md
# Linked Page-List Address Translator

This block turns a virtual trace-buffer address into a physical byte address. It does this by walking a chain of page tables held in memory. Each table occupies a 4KB region. The lower 2KB of the region holds up to 256 page descriptors of 64 bits each, and every descriptor names one 4KB data page. The upper 2KB holds only two link descriptors: the final slot at offset 0xFF8 points to the following table, and the slot just before it, at offset 0xFF0, points to the preceding table. One table therefore covers 1MB of virtual space. Virtual bits [VA_W-1:20] choose the table and bits [19:12] choose the descriptor within it.

The walker keeps a pointer to the table it last used, together with that table's region number. A sync reset loads the pointer from the configured base address and sets the region to zero. A request for a higher region makes the walker follow forward links, one memory read per hop. A request for a lower region makes it follow backward links in the same way. Once the regions match, it reads the indexed descriptor. The physical address takes the descriptor's bits [63:12] and the request's bits [11:0].

Bit 0 of every descriptor, links included, marks it as valid. A fetched descriptor with bit 0 clear marks the end of the chain. The walker then reports a fault instead of going on.

Top module: `sl_walker`

## Requirements
- R1: While reset is high and on the cycle after it falls, req_ready is 1, rsp_valid is 0 and rd_valid is 0. Reset loads the current table pointer from {cfg_base_hi, cfg_base_lo} with bits [11:0] cleared, and sets the current region to 0.
- R2: When the requested region equals the current region, exactly one read is issued, at the current table address + VA[19:12]*8.
- R3: For a valid page descriptor, rsp_pa = {descriptor[63:12], VA[11:0]} and rsp_fault = 0.
- R4: When the requested region is above the current one, the walker reads the forward link at table + 0xFF8. Each valid link makes its bits [63:12] the new table and adds 1 to the region. Each hop costs one read.
- R5: When the requested region is below the current one, the walker reads the backward link at table + 0xFF0 and subtracts 1 from the region on each valid hop.
- R6: A page descriptor with bit 0 = 0 ends the walk with rsp_fault = 1 and rsp_pa = 0.
- R7: A link descriptor with bit 0 = 0 ends the walk with rsp_fault = 1 and rsp_pa = 0. The current table and region stay at the last valid table.
- R8: One translation at a time. req_ready is 0 from the cycle after a request is accepted until the response is taken. rsp_valid, rsp_pa and rsp_fault hold steady until rsp_ready.
- R9: rd_valid and rd_addr hold steady until rd_ack. Every read address is 8-byte aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base_hi | input | 32 | Upper half of the first table's address |
| cfg_base_lo | input | 32 | Lower half of the first table's address |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_va | input | VA_W | Virtual address to translate |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result taken |
| rsp_pa | output | 64 | Physical byte address (0 on fault) |
| rsp_fault | output | 1 | Chain end hit during the walk |
| rd_valid | output | 1 | Memory read request |
| rd_addr | output | 64 | Byte address of the 64-bit descriptor |
| rd_ack | input | 1 | Read data returned this cycle |
| rd_data | input | 64 | Descriptor contents |

## Verification
The bench uses the default VA_W of 32, which gives a 12-bit region number. That is wide enough for a chain of three tables plus a region just past the end, so forward walks of two hops, backward walks of two hops and a run off the end are all reachable. The base address is placed above 4GB, so both configuration halves take part in forming the table pointer. A second reset with a different base shows that region 0 follows the configured table.

// File: rtl/sl_walk_pkg.sv
package sl_walk_pkg;

    localparam int ENT_W    = 64;
    localparam int PAGE_SH  = 12;
    localparam int REGN_SH  = 20;
    localparam int IDX_W    = 8;
    localparam int HI_W     = ENT_W - PAGE_SH;

    localparam logic [PAGE_SH-1:0] FWD_SLOT = 12'hFF8;
    localparam logic [PAGE_SH-1:0] BWD_SLOT = 12'hFF0;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ROUTE,
        ST_FETCH,
        ST_RESP
    } walk_st_e;

    typedef enum logic [1:0] {
        FK_PAGE,
        FK_FWD,
        FK_BWD
    } fetch_kind_e;

    typedef struct packed {
        logic [ENT_W-1:0] pa;
        logic             fault;
    } walk_rsp_t;

    function automatic logic [ENT_W-1:0] table_of(logic [HI_W-1:0] hi);
        return {hi, {PAGE_SH{1'b0}}};
    endfunction

    function automatic logic [ENT_W-1:0] join_pa(logic [HI_W-1:0] hi,
                                                 logic [PAGE_SH-1:0] ofs);
        return {hi, ofs};
    endfunction

endpackage

// File: rtl/sl_list_track.sv
module sl_list_track
    import sl_walk_pkg::*;
#(
    parameter int REG_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [HI_W-1:0]  base_hi,
    input  logic             step_en,
    input  logic             step_fwd,
    input  logic [HI_W-1:0]  link_hi,
    output logic [ENT_W-1:0] cur_table,
    output logic [REG_W-1:0] cur_region
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_table  <= table_of(base_hi);
            cur_region <= '0;
        end else if (step_en) begin
            cur_table  <= table_of(link_hi);
            cur_region <= step_fwd ? cur_region + 1'b1 : cur_region - 1'b1;
        end
    end

endmodule

// File: rtl/sl_fetch_addr.sv
module sl_fetch_addr
    import sl_walk_pkg::*;
(
    input  fetch_kind_e      kind,
    input  logic [ENT_W-1:0] cur_table,
    input  logic [IDX_W-1:0] page_idx,
    output logic [ENT_W-1:0] addr
);

    logic [PAGE_SH-1:0] slot_ofs;

    always_comb begin
        unique case (kind)
            FK_FWD:  slot_ofs = FWD_SLOT;
            FK_BWD:  slot_ofs = BWD_SLOT;
            default: slot_ofs = {1'b0, page_idx, 3'b000};
        endcase
        addr = cur_table + ENT_W'(slot_ofs);
    end

endmodule

// File: rtl/sl_walker.sv
module sl_walker
    import sl_walk_pkg::*;
#(
    parameter int VA_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [31:0]     cfg_base_hi,
    input  logic [31:0]     cfg_base_lo,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_va,
    output logic            rsp_valid,
    input  logic            rsp_ready,
    output logic [63:0]     rsp_pa,
    output logic            rsp_fault,
    output logic            rd_valid,
    output logic [63:0]     rd_addr,
    input  logic            rd_ack,
    input  logic [63:0]     rd_data
);

    localparam int REG_W = VA_W - REGN_SH;

    walk_st_e         state;
    fetch_kind_e      kind_q;
    logic [VA_W-1:0]  va_q;
    walk_rsp_t        rsp_q;
    logic [ENT_W-1:0] cur_table;
    logic [REG_W-1:0] cur_region;
    logic [REG_W-1:0] want_region;
    logic [ENT_W-1:0] base_full;
    logic             hop_ok;
    logic             unused_bits;

    assign base_full   = {cfg_base_hi, cfg_base_lo};
    assign want_region = va_q[VA_W-1:REGN_SH];
    assign hop_ok      = (state == ST_FETCH) && rd_ack && (kind_q != FK_PAGE) && rd_data[0];
    assign unused_bits = ^{rd_data[PAGE_SH-1:1], base_full[PAGE_SH-1:0]};

    sl_list_track #(.REG_W(REG_W)) u_track (
        .clk        (clk),
        .rst        (rst),
        .base_hi    (base_full[ENT_W-1:PAGE_SH]),
        .step_en    (hop_ok),
        .step_fwd   (kind_q == FK_FWD),
        .link_hi    (rd_data[ENT_W-1:PAGE_SH]),
        .cur_table  (cur_table),
        .cur_region (cur_region)
    );

    sl_fetch_addr u_addr (
        .kind      (kind_q),
        .cur_table (cur_table),
        .page_idx  (va_q[REGN_SH-1:PAGE_SH]),
        .addr      (rd_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            kind_q <= FK_PAGE;
            va_q   <= '0;
            rsp_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    va_q  <= req_va;
                    state <= ST_ROUTE;
                end
                ST_ROUTE: begin
                    if (want_region == cur_region)     kind_q <= FK_PAGE;
                    else if (want_region > cur_region) kind_q <= FK_FWD;
                    else                               kind_q <= FK_BWD;
                    state <= ST_FETCH;
                end
                ST_FETCH: if (rd_ack) begin
                    if (!rd_data[0]) begin
                        rsp_q <= '{pa: '0, fault: 1'b1};
                        state <= ST_RESP;
                    end else if (kind_q == FK_PAGE) begin
                        rsp_q <= '{pa: join_pa(rd_data[ENT_W-1:PAGE_SH], va_q[PAGE_SH-1:0]),
                                   fault: 1'b0};
                        state <= ST_RESP;
                    end else begin
                        state <= ST_ROUTE;
                    end
                end
                ST_RESP: if (rsp_ready) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state == ST_IDLE);
    assign rd_valid  = (state == ST_FETCH);
    assign rsp_valid = (state == ST_RESP);
    assign rsp_pa    = rsp_q.pa;
    assign rsp_fault = rsp_q.fault;

endmodule

// File: rtl/sl_walk_chk.sv
module sl_walk_chk #(
    parameter int VA_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic            rsp_ready,
    input logic [63:0]     rsp_pa,
    input logic            rsp_fault,
    input logic            rd_valid,
    input logic            rd_ack,
    input logic [63:0]     rd_addr,
    input logic [VA_W-1:0] va_q
);

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (req_ready && !rsp_valid && !rd_valid));

    // R8
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R8
    resp_excl_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    // R8
    rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_fault)));

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ack) |=> (rd_valid && $stable(rd_addr)));

    // R9
    rd_align_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (rd_addr[2:0] == 3'b000));

    // R6
    fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_pa == 64'd0));

    // R3
    ofs_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fault) |-> (rsp_pa[11:0] == va_q[11:0]));

endmodule

bind sl_walker sl_walk_chk #(.VA_W(VA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_pa    (rsp_pa),
    .rsp_fault (rsp_fault),
    .rd_valid  (rd_valid),
    .rd_ack    (rd_ack),
    .rd_addr   (rd_addr),
    .va_q      (va_q)
);

// File: tb/sl_walker_tb.sv
module sl_walker_tb;

    localparam int VA_W = 32;
    localparam int NV   = 8;

    // Vector table: VA, expected table number (-1 = fault), expected read count
    localparam logic [31:0] VEC_VA [NV] = '{32'h0000_0123, 32'h0010_5ABC, 32'h0020_FFFF,
                                            32'h0030_0000, 32'h0000_1001, 32'h0015_5004,
                                            32'h0020_0ABC, 32'h0011_2FFE};
    localparam int VEC_TBL [NV] = '{0, 1, 2, -1, 0, -1, 2, 1};
    localparam int VEC_RD  [NV] = '{1, 2, 2, 1, 3, 2, 2, 2};

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [31:0]     cfg_base_hi = 32'h1;
    logic [31:0]     cfg_base_lo = 32'h0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [VA_W-1:0] req_va = '0;
    logic            rsp_valid;
    logic            rsp_ready = 1'b0;
    logic [63:0]     rsp_pa;
    logic            rsp_fault;
    logic            rd_valid;
    logic [63:0]     rd_addr;
    logic            rd_ack = 1'b0;
    logic [63:0]     rd_data = '0;

    int n_chk  = 0;
    int n_bad  = 0;
    int n_read = 0;
    logic [63:0] mem [logic [63:0]];
    logic [63:0] got_pa;
    logic        got_fault;

    always #4 clk = ~clk;

    sl_walker #(.VA_W(VA_W)) u_dut (
        .clk(clk), .rst(rst), .cfg_base_hi(cfg_base_hi), .cfg_base_lo(cfg_base_lo),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data)
    );

    function automatic logic [63:0] tbl_addr(int k);
        case (k)
            0:       return 64'h1_0000_0000;
            1:       return 64'h1_0000_3000;
            default: return 64'h1_0000_7000;
        endcase
    endfunction

    function automatic logic [63:0] page_desc(int k, int i);
        return 64'h0000_00A0_0000_0001 | (64'(k) << 24) | (64'(i) << 12);
    endfunction

    function automatic logic [63:0] exp_pa(int k, logic [31:0] va);
        logic [63:0] d;
        d = page_desc(k, int'(va[19:12]));
        return {d[63:12], va[11:0]};
    endfunction

    // memory model: one-cycle read latency
    always @(negedge clk) begin
        if (rd_ack) begin
            rd_ack <= 1'b0;
        end else if (rd_valid) begin
            rd_ack  <= 1'b1;
            rd_data <= mem.exists(rd_addr) ? mem[rd_addr] : 64'd0;
            n_read  <= n_read + 1;
        end
    end

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic translate(logic [31:0] va);
        @(negedge clk);
        n_read    = 0;
        req_va    = va;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        got_pa    = rsp_pa;
        got_fault = rsp_fault;
        repeat (2) begin
            @(negedge clk);
            check("R8 response held", {rsp_valid, rsp_fault, rsp_pa}, {1'b1, got_fault, got_pa});
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    task automatic expect_result(string tag, int k, logic [31:0] va, int reads);
        if (k < 0) begin
            check({tag, " fault flag"}, 64'(got_fault), 64'd1);
            check({tag, " fault pa"}, got_pa, 64'd0);
        end else begin
            check({tag, " ok flag"}, 64'(got_fault), 64'd0);
            check({tag, " pa"}, got_pa, exp_pa(k, va));
        end
        check({tag, " read count"}, 64'(n_read), 64'(reads));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 ready in reset", {req_ready, rsp_valid, rd_valid}, 3'b100);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ready after reset", {req_ready, rsp_valid, rd_valid}, 3'b100);
    endtask

    initial begin
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < 256; i++) mem[tbl_addr(k) + 64'(i * 8)] = page_desc(k, i);
        end
        mem[tbl_addr(0) + 64'hFF8] = tbl_addr(1) | 64'd1;
        mem[tbl_addr(1) + 64'hFF0] = tbl_addr(0) | 64'd1;
        mem[tbl_addr(1) + 64'hFF8] = tbl_addr(2) | 64'd1;
        mem[tbl_addr(2) + 64'hFF0] = tbl_addr(1) | 64'd1;
        mem[tbl_addr(1) + 64'(8'h55 * 8)] = 64'd0;

        do_reset();

        // table walk: R2 (same region), R3, R4 (forward), R5 (backward), R6, R7
        for (int v = 0; v < NV; v++) begin
            translate(VEC_VA[v]);
            expect_result($sformatf("R2/R3/R4/R5/R6/R7 vec%0d", v), VEC_TBL[v], VEC_VA[v], VEC_RD[v]);
        end

        // R5 backward link invalid -> R7 fault, table kept
        translate(32'h0020_0010);
        expect_result("R4 move to table2", 2, 32'h0020_0010, 2);
        mem[tbl_addr(2) + 64'hFF0] = 64'd0;
        translate(32'h0000_0000);
        expect_result("R7 backward end", -1, 32'h0000_0000, 1);
        mem[tbl_addr(2) + 64'hFF0] = tbl_addr(1) | 64'd1;
        translate(32'h0020_0008);
        expect_result("R7 table kept", 2, 32'h0020_0008, 1);

        // R1 new base: region 0 is the configured table
        cfg_base_lo = 32'h0000_3000;
        do_reset();
        translate(32'h0000_0040);
        expect_result("R1 base reload", 1, 32'h0000_0040, 1);
        translate(32'h0010_0FFF);
        expect_result("R4 from new base", 2, 32'h0010_0FFF, 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule